// File: doc/BRIEF.md
# Maskable Interrupt Status Register

This block gathers single-cycle event pulses from a serial link controller's transmit and receive paths into one 8-bit sticky status register. Each of the seven sources has its own mask bit. A host reads the status word over a small register bus. A read shows only the pending sources that are not masked, and it clears exactly those sources. Masked events are not lost. They are latched and kept hidden, and they drive the interrupt line as soon as software clears their mask bit.

The bus has one address bit. Address 0 is the status word, which can be read; writes to it are ignored. Address 1 is the mask word, which can be read and written. A transaction is a single cycle with `bus_sel` high. Read data is combinational in that same cycle, and the register updates take effect at the next clock edge. There is no data stream at the edge of this block, so every pin is a plain level or strobe with no back-pressure.

The block also drives a transmit-inhibit level back to the transmitter. This level stays high while an underrun event has not been acknowledged. The underrun is acknowledged only when a status read actually returns that bit, which means the bit must also be unmasked at the time of the read.

Top module: `isr_irq_status`

## Requirements
- R1: After reset, the status word and the mask word both read 00h, and `irq` and `tx_inhibit` are low.
- R2: A pulse on `evt[k]` sets pending bit k+1. The bit positions are: bit 7 message end, bit 6 pool full, bit 5 frame overflow, bit 4 transmit pool ready, bit 3 transmit underrun, bit 2 transmit overflow, and bit 1 change detect. A pending bit stays set until a status read returns it.
- R3: A status read (`bus_sel`=1, `bus_wr`=0, `bus_addr`=0) returns the pending bits ANDed with the inverse of the mask. Bit 0 always reads 0. When no read is in progress, `bus_rdata` is 00h.
- R4: A status read clears only the bits it returned. Pending bits that are masked stay pending.
- R5: An event that arrives in the same cycle as a status read leaves its bit set after the read.
- R6: `irq` is high exactly when some pending bit is unmasked. A pending bit that was masked raises `irq` in the cycle after its mask bit is cleared.
- R7: A write to address 1 stores all 8 bits of `bus_wdata` as the mask, where a 1 masks a source. A read from address 1 returns the stored mask and does not change any pending bit.
- R8: `tx_inhibit` is high while bit 3 (underrun) is pending, whether or not it is masked. It goes low only after a status read that returns bit 3.
- R9: A write to address 0 has no effect on either register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus transaction strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = status word, 1 = mask word |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same cycle as the read strobe |
| evt | input | 7 | Event pulses; evt[k] sets status bit k+1 |
| irq | output | 1 | Active-high interrupt, the OR of the unmasked pending bits |
| tx_inhibit | output | 1 | High while a transmit underrun is unacknowledged |

## Verification
On every cycle, the assertions check four things. A pending bit never drops unless a read cleared it. A set pulse always leaves its bit set, even during a read. The mask holds its value between writes. Finally, neither `irq` nor `tx_inhibit` can fall without a status read that returned an unmasked bit, or a mask write in the case of `irq`.

Some behaviour only the bench scenarios can show: the read value seen under a given mask, that masked bits are hidden and then resurface after unmasking, and that writes to the status address are ignored. The bench also shows that reading the mask never clears anything, and that a masked underrun keeps the transmitter inhibited.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned SRC_W   = REG_W - 1;
  localparam int unsigned UNDR_IX = 3;

  localparam logic ADDR_STAT = 1'b0;
  localparam logic ADDR_MASK = 1'b1;

  typedef struct packed {
    logic rd_stat;
    logic rd_mask;
    logic wr_mask;
  } bus_strb_t;
endpackage

// File: rtl/isr_bus_decode.sv
module isr_bus_decode
  import isr_pkg::*;
(
  input  logic      sel_i,
  input  logic      wr_i,
  input  logic      addr_i,
  output bus_strb_t strb_o
);
  always_comb begin
    strb_o.rd_stat = sel_i && !wr_i && (addr_i == ADDR_STAT);
    strb_o.rd_mask = sel_i && !wr_i && (addr_i == ADDR_MASK);
    // Writes to the status address decode to nothing (R9).
    strb_o.wr_mask = sel_i &&  wr_i && (addr_i == ADDR_MASK);
  end
endmodule

// File: rtl/isr_mask_reg.sv
module isr_mask_reg #(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] mask_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_o <= '0;
    else if (wr_en_i) mask_o <= wdata_i;
  end

  assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(mask_o));
  assert_mask_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (mask_o == $past(wdata_i)));
endmodule

// File: rtl/isr_pending_bank.sv
module isr_pending_bank #(
  parameter int unsigned REG_W = 8,
  localparam int unsigned SRC_W = REG_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] set_i,
  input  logic [SRC_W-1:0] clr_i,
  output logic [REG_W-1:0] pend_o
);
  assign pend_o[0] = 1'b0;

  for (genvar i = 1; i < REG_W; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= set_i[i-1] | (q & ~clr_i[i-1]);
    end
    assign pend_o[i] = q;

    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (q && !clr_i[i-1]) |=> q);
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i-1] |=> q);
    assert_clear_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i-1] && !set_i[i-1]) |=> !q);
  end
endmodule

// File: rtl/isr_irq_status.sv
module isr_irq_status
  import isr_pkg::*;
#(
  parameter int unsigned REG_W   = isr_pkg::REG_W,
  parameter int unsigned UNDR_IX = isr_pkg::UNDR_IX,
  localparam int unsigned SRC_W  = REG_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic             bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic [SRC_W-1:0] evt,
  output logic             irq,
  output logic             tx_inhibit
);
  bus_strb_t        strb;
  logic [REG_W-1:0] mask_q;
  logic [REG_W-1:0] pend_q;
  logic [REG_W-1:0] visible;
  logic [SRC_W-1:0] clr;

  isr_bus_decode u_dec (
    .sel_i  (bus_sel),
    .wr_i   (bus_wr),
    .addr_i (bus_addr),
    .strb_o (strb)
  );

  isr_mask_reg #(.REG_W(REG_W)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (strb.wr_mask),
    .wdata_i (bus_wdata),
    .mask_o  (mask_q)
  );

  isr_pending_bank #(.REG_W(REG_W)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (evt),
    .clr_i  (clr),
    .pend_o (pend_q)
  );

  always_comb begin
    visible = pend_q & ~mask_q;
    clr     = strb.rd_stat ? visible[REG_W-1:1] : '0;
    if (strb.rd_stat)      bus_rdata = visible;
    else if (strb.rd_mask) bus_rdata = mask_q;
    else                   bus_rdata = '0;
  end

  assign irq        = |visible;
  assign tx_inhibit = pend_q[UNDR_IX];

  assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !strb.rd_stat && !strb.wr_mask) |=> irq);
  assert_inhibit_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_inhibit && !(strb.rd_stat && !mask_q[UNDR_IX])) |=> tx_inhibit);
  assert_rd_bit0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.rd_stat |-> !bus_rdata[0]);
  assert_idle_rdata_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> (bus_rdata == '0));
endmodule

// File: tb/isr_irq_status_tb_top.sv
module isr_irq_status_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [6:0] evt = '0;
  logic       irq, tx_inhibit;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  isr_irq_status dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt(evt), .irq(irq), .tx_inhibit(tx_inhibit)
  );

  // op: 0 idle, 1 read status, 2 read mask, 3 write status, 4 write mask
  // fields: {op[3], wdata[8], evt[7], exp_rdata[8], exp_irq, exp_inhibit}
  localparam int NV = 27;
  localparam logic [27:0] VEC [0:NV-1] = '{
    {3'd0, 8'h00, 7'h00, 8'h00, 1'b0, 1'b0},  // R1 reset state
    {3'd0, 8'h00, 7'h40, 8'h00, 1'b0, 1'b0},  // R2 message end
    {3'd1, 8'h00, 7'h00, 8'h80, 1'b1, 1'b0},  // R3 read returns it
    {3'd1, 8'h00, 7'h00, 8'h00, 1'b0, 1'b0},  // R4 cleared
    {3'd4, 8'h48, 7'h00, 8'h00, 1'b0, 1'b0},  // R7 mask 48
    {3'd2, 8'h00, 7'h00, 8'h48, 1'b0, 1'b0},  // R7 readback
    {3'd0, 8'h00, 7'h25, 8'h00, 1'b0, 1'b0},  // R2 pool full, underrun, change
    {3'd0, 8'h00, 7'h00, 8'h00, 1'b1, 1'b1},  // R6 R8
    {3'd1, 8'h00, 7'h00, 8'h02, 1'b1, 1'b1},  // R3 masked hidden
    {3'd0, 8'h00, 7'h00, 8'h00, 1'b0, 1'b1},  // R4 masked still pending
    {3'd1, 8'h00, 7'h00, 8'h00, 1'b0, 1'b1},  // R4
    {3'd4, 8'h08, 7'h00, 8'h00, 1'b0, 1'b1},  // R6 unmask pool full
    {3'd0, 8'h00, 7'h00, 8'h00, 1'b1, 1'b1},  // R6 irq after unmask
    {3'd4, 8'h00, 7'h00, 8'h00, 1'b1, 1'b1},
    {3'd1, 8'h00, 7'h04, 8'h48, 1'b1, 1'b1},  // R5 underrun during read
    {3'd0, 8'h00, 7'h00, 8'h00, 1'b1, 1'b1},  // R5 stayed set
    {3'd3, 8'hFF, 7'h00, 8'h00, 1'b1, 1'b1},  // R9 status write
    {3'd1, 8'h00, 7'h00, 8'h08, 1'b1, 1'b1},  // R9 nothing changed
    {3'd0, 8'h00, 7'h00, 8'h00, 1'b0, 1'b0},  // R8 acked
    {3'd4, 8'hFF, 7'h00, 8'h00, 1'b0, 1'b0},
    {3'd2, 8'h00, 7'h00, 8'hFF, 1'b0, 1'b0},  // R7 all 8 bits
    {3'd0, 8'h00, 7'h7F, 8'h00, 1'b0, 1'b0},  // R2 all sources
    {3'd1, 8'h00, 7'h00, 8'h00, 1'b0, 1'b1},  // R3 R8 masked underrun
    {3'd2, 8'h00, 7'h00, 8'hFF, 1'b0, 1'b1},  // R7 mask read no clear
    {3'd4, 8'h00, 7'h00, 8'h00, 1'b0, 1'b1},
    {3'd1, 8'h00, 7'h00, 8'hFE, 1'b1, 1'b1},  // R4 R6 all resurface
    {3'd0, 8'h00, 7'h00, 8'h00, 1'b0, 1'b0}   // R8 released
  };

  task automatic drive(input logic [2:0] op, input logic [7:0] wd, input logic [6:0] ev);
    bus_sel   = (op != 3'd0);
    bus_wr    = (op >= 3'd3);
    bus_addr  = (op == 3'd2) || (op == 3'd4);
    bus_wdata = wd;
    evt       = ev;
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      drive(VEC[v][27:25], VEC[v][24:17], VEC[v][16:10]);
      #5;
      check($sformatf("R3 v%0d rdata", v), bus_rdata, VEC[v][9:2]);
      check($sformatf("R6 v%0d irq", v), {7'd0, irq}, {7'd0, VEC[v][1]});
      check($sformatf("R8 v%0d tx_inhibit", v), {7'd0, tx_inhibit}, {7'd0, VEC[v][0]});
    end

    // R1: reset in the middle of activity clears both registers
    @(negedge clk); drive(3'd4, 8'h0F, 7'h7F);
    @(negedge clk); drive(3'd0, 8'h00, 7'h00);
    #5;
    check("R1 pre-reset irq", {7'd0, irq}, 8'h01);
    rst_n = 1'b0;
    #2;
    check("R1 irq in reset", {7'd0, irq}, 8'h00);
    check("R1 inhibit in reset", {7'd0, tx_inhibit}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); drive(3'd2, 8'h00, 7'h00); #5;
    check("R1 mask after reset", bus_rdata, 8'h00);
    @(negedge clk); drive(3'd1, 8'h00, 7'h00); #5;
    check("R1 status after reset", bus_rdata, 8'h00);

    // R5: an event during a read of a different, unmasked bit
    @(negedge clk); drive(3'd0, 8'h00, 7'h01);
    @(negedge clk); drive(3'd1, 8'h00, 7'h10); #5;
    check("R5 read returns change", bus_rdata, 8'h02);
    @(negedge clk); drive(3'd1, 8'h00, 7'h00); #5;
    check("R5 late event kept", bus_rdata, 8'h20);
    @(negedge clk); drive(3'd0, 8'h00, 7'h00); #5;
    check("R4 all clear", {7'd0, irq}, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule